// File: doc/BRIEF.md
# Gated Retriggerable One-Shot Timer

This block is a clock-synchronous monostable pulse generator. Three level inputs gate its triggering: an active-low arm input, an active-high arm input and an active-low clear. The inputs must already be synchronous to the clock.

A trigger is an edge on one of the three inputs while the other two stand at their enabling levels. When a trigger is accepted, the pulse output rises for a number of clock cycles taken from a length input at that moment. A complementary output is also provided.

A new trigger during a running pulse restarts the full length, so frequent triggers hold the output high without a break. Triggers that arrive within a short fixed lockout after an accepted trigger are dropped. Holding clear low ends any pulse at the next clock edge.

Top module: `retrig_oneshot`

## Requirements
- R1: During and right after reset, `pulse_q` is 0 and `pulse_qn` is 1.
- R2: `pulse_qn` is always the inverse of `pulse_q`.
- R3: When `clr_n` is sampled low at a clock edge, `pulse_q` is 0 after that edge, whatever `arm_n` and `arm_p` do.
- R4: A rising edge of `arm_p` (low in the previous cycle, high now) while `arm_n` is 0 and `clr_n` is 1 is a trigger.
- R5: A falling edge of `arm_n` while `arm_p` is 1 and `clr_n` is 1 is a trigger.
- R6: A rising edge of `clr_n` while `arm_n` is 0 and `arm_p` is 1 is a trigger.
- R7: A steady high on `arm_n` or a steady low on `arm_p` never starts a pulse. A pulse that is already running still completes its full length.
- R8: An accepted trigger sampled at edge k makes `pulse_q` high for exactly `len` cycles, starting after edge k. A `len` of 0 gives no pulse.
- R9: A trigger accepted while a pulse is running reloads the full `len` from that trigger.
- R10: Triggers sampled in the LOCK cycles that follow an accepted trigger are ignored, and the end time of the pulse stays unchanged. LOCK is 3 by default.
- R11: `len` is sampled only at an accepted trigger. Changing it during a pulse does not alter that pulse.
- R12: An arm edge that occurs while `clr_n` is low starts nothing, either then or in later cycles.
- R13: Triggers spaced more than LOCK and fewer than `len` cycles apart keep `pulse_q` high without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_n | input | 1 | Active-low arm input; its falling edge triggers |
| arm_p | input | 1 | Active-high arm input; its rising edge triggers |
| clr_n | input | 1 | Active-low clear; its rising edge can trigger |
| len | input | WIDTH | Pulse length in clock cycles |
| pulse_q | output | 1 | Pulse output |
| pulse_qn | output | 1 | Complement of the pulse output |

## Verification
The assertions assume that all three gating inputs are already synchronous to `clk` and change only between edges. They also assume that the inputs sit at their idle levels (`arm_n` high, `arm_p` low, `clr_n` high) while reset is held, so that the first edge comparison after reset starts from known history.

The stimulus holds those idle levels through reset. Every input is changed only on the falling clock edge. In the random phase, `clr_n` is kept high most of the time and `len` ranges over small values, so that the stimulus reaches lockout, retrigger and clear collisions often.

// File: rtl/oneshot_pkg.sv
`timescale 1ns/1ps
package oneshot_pkg;

    typedef struct packed {
        logic arm_n;
        logic arm_p;
        logic clr_n;
    } gate_lvl_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_ARMP = 2'd1,
        SRC_ARMN = 2'd2,
        SRC_CLR  = 2'd3
    } trig_src_e;

    localparam gate_lvl_t GATE_IDLE = '{arm_n: 1'b1, arm_p: 1'b0, clr_n: 1'b1};

endpackage

// File: rtl/oneshot_trig.sv
`timescale 1ns/1ps
module oneshot_trig
    import oneshot_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  gate_lvl_t lvl,
    output trig_src_e src
);

    gate_lvl_t prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= GATE_IDLE;
        else        prev_q <= prev_d;
    end

    // Edge qualification; clear low blocks every path
    always_comb begin
        src = SRC_NONE;
        if (lvl.clr_n && !lvl.arm_n && lvl.arm_p && !prev_q.clr_n)
            src = SRC_CLR;
        else if (lvl.clr_n && !lvl.arm_n && lvl.arm_p && !prev_q.arm_p)
            src = SRC_ARMP;
        else if (lvl.clr_n && lvl.arm_p && !lvl.arm_n && prev_q.arm_n)
            src = SRC_ARMN;
    end

    p_armn_fall_fires_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl.clr_n && lvl.arm_p && !lvl.arm_n && $past(lvl.arm_n)) |-> (src != SRC_NONE));

    p_armp_rise_fires_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl.clr_n && !lvl.arm_n && lvl.arm_p && !$past(lvl.arm_p)) |-> (src != SRC_NONE));

endmodule

// File: rtl/oneshot_core.sv
`timescale 1ns/1ps
module oneshot_core #(
    parameter int WIDTH = 8,
    parameter int LOCK  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] len,
    output logic             active
);

    localparam int LW = $clog2(LOCK + 1);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
        logic [LW-1:0]    lock;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.lock != '0) s_d.lock = s_q.lock - 1'b1;
        if (s_q.cnt  != '0) s_d.cnt  = s_q.cnt - 1'b1;
        if (!clr_n) begin
            s_d.cnt  = '0;
            s_d.lock = '0;
        end else if (trig && (s_q.lock == '0)) begin
            s_d.cnt  = len;
            s_d.lock = LW'(LOCK);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active = (s_q.cnt != '0);

    p_clear_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (s_q.cnt == '0));

    p_load_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && trig && (s_q.lock == '0)) |=> (s_q.cnt == $past(len)));

    p_lock_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && (s_q.lock != '0) && (s_q.cnt != '0)) |=> (s_q.cnt == $past(s_q.cnt) - 1'b1));

    p_idle_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && (s_q.cnt == '0)) |=> (s_q.cnt == '0));

    p_len_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !trig && (s_q.cnt != '0)) |=> (s_q.cnt == $past(s_q.cnt) - 1'b1));

endmodule

// File: rtl/retrig_oneshot.sv
`timescale 1ns/1ps
module retrig_oneshot
    import oneshot_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int LOCK  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_n,
    input  logic             arm_p,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] len,
    output logic             pulse_q,
    output logic             pulse_qn
);

    gate_lvl_t lvl;
    trig_src_e src;
    logic      active;

    assign lvl = '{arm_n: arm_n, arm_p: arm_p, clr_n: clr_n};

    oneshot_trig u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .src   (src)
    );

    oneshot_core #(
        .WIDTH (WIDTH),
        .LOCK  (LOCK)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (src != SRC_NONE),
        .clr_n  (clr_n),
        .len    (len),
        .active (active)
    );

    assign pulse_q  = active;
    assign pulse_qn = ~active;

    p_low_after_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> !pulse_q);

    p_outputs_opposite_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q != pulse_qn);

endmodule

// File: tb/retrig_oneshot_tb.sv
`timescale 1ns/1ps
module retrig_oneshot_tb;

    localparam int W = 8;
    localparam int L = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm_n = 1'b1, arm_p = 1'b0, clr_n = 1'b1;
    logic [W-1:0] len = '0;
    logic pulse_q, pulse_qn;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_cnt = 0, m_lock = 0;
    logic pa = 1'b1, pb = 1'b0, pc = 1'b1;
    int hi_run = 0;

    always #5 clk = ~clk;

    retrig_oneshot #(.WIDTH(W), .LOCK(L)) u_dut (
        .clk(clk), .rst_n(rst_n), .arm_n(arm_n), .arm_p(arm_p),
        .clr_n(clr_n), .len(len), .pulse_q(pulse_q), .pulse_qn(pulse_qn)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic bit is_trig(input logic a, input logic b, input logic c);
        if (!c) return 1'b0;
        if (!a && b && !pc) return 1'b1;
        if (!a && b && !pb) return 1'b1;
        if (b && !a && pa) return 1'b1;
        return 1'b0;
    endfunction

    // One cycle: check outputs against the expected state, then drive new inputs
    task automatic step(input string tag, input logic a, input logic b, input logic c,
                        input logic [W-1:0] n);
        int nc, nl;
        @(negedge clk);
        chk(tag, pulse_q, (m_cnt != 0) ? 1 : 0);
        chk("R2", pulse_qn, (m_cnt != 0) ? 0 : 1);
        if (pulse_q) hi_run++;
        arm_n = a; arm_p = b; clr_n = c; len = n;
        nl = (m_lock > 0) ? m_lock - 1 : 0;
        nc = (m_cnt > 0) ? m_cnt - 1 : 0;
        if (!c) begin
            nc = 0; nl = 0;
        end else if (is_trig(a, b, c) && m_lock == 0) begin
            nc = int'(n); nl = L;
        end
        m_cnt = nc; m_lock = nl;
        pa = a; pb = b; pc = c;
    endtask

    task automatic idle(input string tag, input int k, input logic a, input logic b,
                        input logic [W-1:0] n);
        for (int i = 0; i < k; i++) step(tag, a, b, 1'b1, n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", pulse_q, 0);
        chk("R1", pulse_qn, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", pulse_q, 0);

        // R4 and R8: arm_p rise, exact length 5
        step("R4", 1'b0, 1'b0, 1'b1, 8'd5);
        hi_run = 0;
        step("R4", 1'b0, 1'b1, 1'b1, 8'd5);
        idle("R8", 10, 1'b0, 1'b1, 8'd5);
        chk("R8", hi_run, 5);

        // R8: zero length gives no pulse
        step("R8", 1'b0, 1'b0, 1'b1, 8'd0);
        hi_run = 0;
        step("R8", 1'b0, 1'b1, 1'b1, 8'd0);
        idle("R8", 4, 1'b0, 1'b1, 8'd0);
        chk("R8", hi_run, 0);

        // R5: arm_n fall with arm_p high
        step("R5", 1'b1, 1'b1, 1'b1, 8'd4);
        step("R5", 1'b0, 1'b1, 1'b1, 8'd4);
        idle("R5", 7, 1'b0, 1'b1, 8'd4);

        // R3 and R6: clear held, then released with arms enabled
        step("R3", 1'b0, 1'b1, 1'b0, 8'd6);
        step("R3", 1'b0, 1'b1, 1'b0, 8'd6);
        step("R6", 1'b0, 1'b1, 1'b1, 8'd6);
        idle("R6", 3, 1'b0, 1'b1, 8'd6);
        step("R3", 1'b0, 1'b1, 1'b0, 8'd6);
        idle("R3", 3, 1'b1, 1'b0, 8'd6);

        // R10: retriggers inside lockout leave length unchanged
        hi_run = 0;
        step("R10", 1'b0, 1'b1, 1'b1, 8'd7);
        step("R10", 1'b0, 1'b0, 1'b1, 8'd7);
        step("R10", 1'b0, 1'b1, 1'b1, 8'd7);
        idle("R10", 10, 1'b0, 1'b1, 8'd7);
        chk("R10", hi_run, 7);

        // R9: retrigger after lockout reloads full length
        step("R9", 1'b0, 1'b0, 1'b1, 8'd6);
        hi_run = 0;
        step("R9", 1'b0, 1'b1, 1'b1, 8'd6);
        idle("R9", 3, 1'b0, 1'b1, 8'd6);
        step("R9", 1'b0, 1'b0, 1'b1, 8'd6);
        step("R9", 1'b0, 1'b1, 1'b1, 8'd6);
        idle("R9", 10, 1'b0, 1'b1, 8'd6);
        chk("R9", hi_run, 11);

        // R11: length change mid-pulse has no effect
        step("R11", 1'b0, 1'b0, 1'b1, 8'd4);
        hi_run = 0;
        step("R11", 1'b0, 1'b1, 1'b1, 8'd4);
        idle("R11", 8, 1'b0, 1'b1, 8'd9);
        chk("R11", hi_run, 4);

        // R12: arm edge during clear starts nothing
        step("R12", 1'b0, 1'b0, 1'b0, 8'd5);
        hi_run = 0;
        step("R12", 1'b0, 1'b1, 1'b0, 8'd5);
        step("R12", 1'b1, 1'b1, 1'b0, 8'd5);
        idle("R12", 5, 1'b1, 1'b1, 8'd5);
        chk("R12", hi_run, 0);

        // R7: steady disabling levels never start; running pulse completes
        hi_run = 0;
        for (int i = 0; i < 4; i++) begin
            step("R7", 1'b1, 1'b1, 1'b1, 8'd5);
            step("R7", 1'b1, 1'b0, 1'b1, 8'd5);
        end
        chk("R7", hi_run, 0);
        step("R7", 1'b0, 1'b0, 1'b1, 8'd5);
        step("R7", 1'b0, 1'b1, 1'b1, 8'd5);
        hi_run = 0;
        idle("R7", 8, 1'b1, 1'b0, 8'd5);
        chk("R7", hi_run, 5);

        // R13: triggers every 5 cycles with length 8 keep output high
        step("R13", 1'b0, 1'b0, 1'b1, 8'd8);
        step("R13", 1'b0, 1'b1, 1'b1, 8'd8);
        hi_run = 0;
        for (int r = 0; r < 8; r++) begin
            idle("R13", 3, 1'b0, 1'b1, 8'd8);
            step("R13", 1'b0, 1'b0, 1'b1, 8'd8);
            step("R13", 1'b0, 1'b1, 1'b1, 8'd8);
        end
        chk("R13", hi_run, 40);
        idle("R13", 10, 1'b1, 1'b0, 8'd8);

        // Random phase against the expected-value functions
        void'($urandom(32'h5eed_0123));
        for (int i = 0; i < 3000; i++) begin
            logic ra, rb, rc;
            logic [W-1:0] rn;
            ra = 1'($urandom_range(0, 1));
            rb = 1'($urandom_range(0, 1));
            rc = ($urandom_range(0, 9) != 0);
            rn = W'($urandom_range(0, 12));
            step("R9", ra, rb, rc, rn);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule